// File: doc/BRIEF.md
# Programmable Pin Mode Controller

This block manages a small group of programmable I/O pins. Each pin gets a two-bit mode that turns it into a plain input, a wake-up input that catches a high-to-low transition and raises an oscillator-enable flag, a plain output driven from a software level bit, or a buffered pass-through for a serial interface. In pass-through mode each pin has a fixed job: the first pin feeds the serial data-out line, the second and third pins copy the serial data-in and clock lines, and the fourth pin copies the chip select inverted. Pins two and three copy their serial line only while chip select is high and fall back to their level bits while it is low.

Software reaches the block through a simple write/read register port with four word addresses: modes, levels, pull-ups and the wake flag. All pin and serial inputs go through a two-flop synchronizer. Every pin output, output enable, pull-up control and the data-out line is registered. A change on an input therefore reaches the outputs three clock cycles later, and a register write takes effect one cycle after it is issued.

Top module: `pin_mode_ctrl`

## Requirements
- R1: After synchronous reset every mode field is 00, and pin_oe, pin_out, pin_pu, osc_en and spi_dout are all 0.
- R2: The mode register sits at address 0. Pin k (k = 0..3) takes bits [2k+1:2k]. The encoding is 00 general input, 01 wake-up, 10 general output, 11 serial pass-through. A read returns the last written value.
- R3: In modes 00 and 01 a pin never drives (pin_oe 0). Reading the level register at address 1 returns the pin's synchronized input level in bit k.
- R4: In mode 01 a high-to-low transition on a pin sets osc_en. A rising transition, or a falling one in any other mode, leaves osc_en unchanged.
- R5: osc_en stays set until software writes a 1 to bit 0 of address 3. A read of address 3 returns osc_en in bit 0.
- R6: In mode 10, pins 2 to 4 drive level bit k with pin_oe 1. Pin 1 never has pin_oe set in any mode. A level read returns the written bit for a pin in mode 10.
- R7: spi_dout equals the level on pin 1 while pin 1 is in mode 11 and chip select is high, and is 0 otherwise. With chip select low, pin 1's level reads back through bit 0 of address 1.
- R8: Pin 2 in mode 11 drives spi_din while chip select is high and level bit 1 while it is low, with pin_oe 1.
- R9: Pin 3 in mode 11 drives spi_sclk while chip select is high and level bit 2 while it is low, with pin_oe 1.
- R10: Pin 4 in mode 11 always drives the inverse of chip select, with pin_oe 1.
- R11: pin_pu[k] equals pull-up bit k (address 2) while pin k is not driving, and is 0 while it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 modes, 1 levels, 2 pull-ups, 3 wake flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr of the previous cycle |
| pin_in | input | 4 | Level seen at each pin |
| pin_out | output | 4 | Value each pin drives |
| pin_oe | output | 4 | Output enable per pin |
| pin_pu | output | 4 | Pull-up enable per pin |
| spi_cs | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_din | input | 1 | Serial data into the device |
| spi_dout | output | 1 | Serial data out of the device |
| osc_en | output | 1 | Oscillator-enable flag |

## Verification
The assertions assume that reset is applied before the first checked cycle and that software writes only the four defined addresses. They also assume that chip select and the pins may change at any clock. The properties therefore compare outputs only with the synchronized inputs and the mode register of the cycle before. The stimulus changes pin and serial inputs on the falling clock edge and holds them for several cycles, longer than the synchronizer and output register together, before any output is sampled. Mode changes are made only through the register port.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_GPIN  = 2'b00,
    PM_WAKE  = 2'b01,
    PM_GPOUT = 2'b10,
    PM_SERIAL = 2'b11
  } pin_mode_e;

  localparam int MODE_W = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_LEVEL = 2'd1;
  localparam logic [ADDR_W-1:0] A_PULL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_WAKE  = 2'd3;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int N_PINS = 4,
  localparam int DATA_W = MODE_W * N_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_PINS-1:0] pin_s,
  output logic [DATA_W-1:0] mode_q,
  output logic [N_PINS-1:0] lvl_q,
  output logic [N_PINS-1:0] pu_q,
  output logic              osc_q,
  output logic [DATA_W-1:0] rdata
);
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] is_wake;
  logic [N_PINS-1:0] lvl_rb;
  logic              wake_hit;
  logic              wake_clr;

  always_comb begin
    for (int k = 0; k < N_PINS; k++) begin
      is_wake[k] = (pin_mode_e'(mode_q[MODE_W*k +: MODE_W]) == PM_WAKE);
      if (pin_mode_e'(mode_q[MODE_W*k +: MODE_W]) == PM_GPOUT ||
          (pin_mode_e'(mode_q[MODE_W*k +: MODE_W]) == PM_SERIAL && k != 0))
        lvl_rb[k] = lvl_q[k];
      else
        lvl_rb[k] = pin_s[k];
    end
  end

  assign wake_hit = |(prev_q & ~pin_s & is_wake);
  assign wake_clr = we && (addr == A_WAKE) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      lvl_q  <= '0;
      pu_q   <= '0;
      osc_q  <= 1'b0;
      prev_q <= '0;
      rdata  <= '0;
    end else begin
      prev_q <= pin_s;
      osc_q  <= wake_hit | (osc_q & ~wake_clr);
      if (we) begin
        case (addr)
          A_MODE:  mode_q <= wdata;
          A_LEVEL: lvl_q  <= wdata[N_PINS-1:0];
          A_PULL:  pu_q   <= wdata[N_PINS-1:0];
          default: ;
        endcase
      end
      case (addr)
        A_MODE:  rdata <= mode_q;
        A_LEVEL: rdata <= {{(DATA_W-N_PINS){1'b0}}, lvl_rb};
        A_PULL:  rdata <= {{(DATA_W-N_PINS){1'b0}}, pu_q};
        default: rdata <= {{(DATA_W-1){1'b0}}, osc_q};
      endcase
    end
  end
endmodule

// File: rtl/pmc_pin_slice.sv
module pmc_pin_slice
  import pmc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              lvl,
  input  logic              pu,
  input  logic              cs,
  input  logic              sclk,
  input  logic              din,
  output logic              out_q,
  output logic              oe_q,
  output logic              pu_q
);
  logic out_d;
  logic oe_d;

  always_comb begin
    out_d = 1'b0;
    oe_d  = 1'b0;
    case (pin_mode_e'(mode))
      PM_GPOUT: begin
        oe_d  = (IDX != 0);
        out_d = (IDX != 0) ? lvl : 1'b0;
      end
      PM_SERIAL: begin
        if (IDX == 1) begin
          oe_d  = 1'b1;
          out_d = cs ? din : lvl;
        end else if (IDX == 2) begin
          oe_d  = 1'b1;
          out_d = cs ? sclk : lvl;
        end else if (IDX == 3) begin
          oe_d  = 1'b1;
          out_d = ~cs;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      pu_q  <= pu & ~oe_d;
    end
  end
endmodule

// File: rtl/pin_mode_ctrl.sv
module pin_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = MODE_W * N_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_pu,
  input  logic              spi_cs,
  input  logic              spi_sclk,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              osc_en
);
  localparam int SYNC_W = N_PINS + 3;

  logic [SYNC_W-1:0] sync_q;
  logic [N_PINS-1:0] pin_s;
  logic              cs_s;
  logic              sclk_s;
  logic              din_s;
  logic [DATA_W-1:0] mode_q;
  logic [N_PINS-1:0] lvl_q;
  logic [N_PINS-1:0] pu_q;
  logic              dout_q;

  pmc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_din, spi_sclk, spi_cs, pin_in}),
    .q   (sync_q)
  );

  assign pin_s  = sync_q[N_PINS-1:0];
  assign cs_s   = sync_q[N_PINS];
  assign sclk_s = sync_q[N_PINS+1];
  assign din_s  = sync_q[N_PINS+2];

  pmc_regs #(.N_PINS(N_PINS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .pin_s  (pin_s),
    .mode_q (mode_q),
    .lvl_q  (lvl_q),
    .pu_q   (pu_q),
    .osc_q  (osc_en),
    .rdata  (reg_rdata)
  );

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    pmc_pin_slice #(.IDX(k)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .mode  (mode_q[MODE_W*k +: MODE_W]),
      .lvl   (lvl_q[k]),
      .pu    (pu_q[k]),
      .cs    (cs_s),
      .sclk  (sclk_s),
      .din   (din_s),
      .out_q (pin_out[k]),
      .oe_q  (pin_oe[k]),
      .pu_q  (pin_pu[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b0;
    else     dout_q <= (pin_mode_e'(mode_q[MODE_W-1:0]) == PM_SERIAL) && cs_s && pin_s[0];
  end

  assign spi_dout = dout_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int N_PINS = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] mode_q,
  input logic              cs_s,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe,
  input logic              spi_dout,
  input logic              osc_en
);
  logic any_wake;
  always_comb begin
    any_wake = 1'b0;
    for (int k = 0; k < N_PINS; k++)
      if (mode_q[2*k +: 2] == 2'b01) any_wake = 1'b1;
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && osc_en == 1'b0 && spi_dout == 1'b0));

  // R6
  p_pin1_never_drives_r6: assert property (@(posedge clk) disable iff (rst)
    pin_oe[0] == 1'b0);

  // R3
  p_input_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q[3] == 1'b0) |=> (pin_oe[1] == 1'b0));

  // R7
  p_dout_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1:0] != 2'b11 || !cs_s) |=> (spi_dout == 1'b0));

  // R10
  p_pin4_inverts_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_q[7:6] == 2'b11) |=> (pin_oe[3] && pin_out[3] == !$past(cs_s)));

  // R5
  p_osc_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (osc_en && !(reg_we && reg_addr == 2'd3 && reg_wdata[0])) |=> osc_en);

  // R4
  p_osc_needs_wake_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> $past(any_wake));
endmodule

bind pin_mode_ctrl pmc_checker #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mode_q    (mode_q),
  .cs_s      (cs_s),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .spi_dout  (spi_dout),
  .osc_en    (osc_en)
);

// File: tb/sim_pin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pin_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] pin_in = 4'd0;
  logic [3:0] pin_out, pin_oe, pin_pu;
  logic       spi_cs = 1'b1, spi_sclk = 1'b0, spi_din = 1'b0;
  logic       spi_dout, osc_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_mode_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_din(spi_din),
    .spi_dout(spi_dout), .osc_en(osc_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pin_oe", {4'd0, pin_oe}, 8'h00);
    check("R1 pin_out", {4'd0, pin_out}, 8'h00);
    check("R1 pin_pu", {4'd0, pin_pu}, 8'h00);
    check("R1 osc_en/dout", {6'd0, osc_en, spi_dout}, 8'h00);
    rd(2'd0, v);
    check("R1 mode", v, 8'h00);
  endtask

  task automatic t_mode_rw();
    logic [7:0] v;
    wr(2'd0, 8'hE4);
    rd(2'd0, v);
    check("R2 mode readback E4", v, 8'hE4);
    wr(2'd0, 8'h1B);
    rd(2'd0, v);
    check("R2 mode readback 1B", v, 8'h1B);
  endtask

  task automatic t_gpin();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    pin_in = 4'b1010; settle();
    rd(2'd1, v);
    check("R3 level read 1010", v, 8'h0A);
    check("R3 no drive", {4'd0, pin_oe}, 8'h00);
    pin_in = 4'b0101; settle();
    rd(2'd1, v);
    check("R3 level read 0101", v, 8'h05);
  endtask

  task automatic t_gpout();
    logic [7:0] v;
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'h05);
    settle();
    check("R6 oe", {4'd0, pin_oe}, 8'h0E);
    check("R6 out 0101", {4'd0, pin_out}, 8'h04);
    rd(2'd1, v);
    check("R6 readback", v, 8'h05);
    wr(2'd1, 8'h0A);
    settle();
    check("R6 out 1010", {4'd0, pin_out}, 8'h0A);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    wr(2'd0, 8'h55);
    pin_in = 4'b1111; settle();
    wr(2'd3, 8'h01); settle();
    check("R4 idle high no wake", {7'd0, osc_en}, 8'h00);
    pin_in = 4'b1101; settle();
    check("R4 fall sets osc", {7'd0, osc_en}, 8'h01);
    wr(2'd0, 8'h55); wr(2'd1, 8'h0F); settle();
    check("R5 sticky", {7'd0, osc_en}, 8'h01);
    rd(2'd3, v);
    check("R5 read flag", v, 8'h01);
    wr(2'd3, 8'h00); settle();
    check("R5 write 0 keeps", {7'd0, osc_en}, 8'h01);
    wr(2'd3, 8'h01); settle();
    check("R5 clear", {7'd0, osc_en}, 8'h00);
    pin_in = 4'b1111; settle();
    check("R4 rise no wake", {7'd0, osc_en}, 8'h00);
    wr(2'd0, 8'h00); settle();
    pin_in = 4'b0000; settle();
    check("R4 fall in GPI ignored", {7'd0, osc_en}, 8'h00);
  endtask

  task automatic t_serial_cs_low();
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h06);
    spi_cs = 1'b0; spi_din = 1'b0; spi_sclk = 1'b0; pin_in = 4'b0001;
    settle();
    rd(2'd1, v);
    check("R7 pin1 readable cs low", v, 8'h07);
    check("R7 dout idle cs low", {7'd0, spi_dout}, 8'h00);
    check("R8 R9 R10 cs low out", {4'd0, pin_out}, 8'h0E);
  endtask

  task automatic t_pullup();
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'h00); settle();
    check("R11 pu inputs", {4'd0, pin_pu}, 8'h0F);
    wr(2'd0, 8'hAA); settle();
    check("R11 pu gpout", {4'd0, pin_pu}, 8'h01);
    wr(2'd0, 8'hFF); settle();
    check("R11 pu serial", {4'd0, pin_pu}, 8'h01);
  endtask

  task automatic t_sweep();
    logic [3:0] lv;
    lv = 4'b0110;
    wr(2'd1, {4'd0, lv});
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, {4{m[1:0]}});
      for (int c = 0; c < 2; c++) begin
        for (int pat = 0; pat < 2; pat++) begin
          logic [3:0] eo, ee;
          logic       ed;
          spi_cs = c[0];
          spi_din = (pat == 0);
          spi_sclk = (pat == 1);
          pin_in = (pat == 0) ? 4'b0101 : 4'b1010;
          settle();
          eo = 4'd0; ee = 4'd0;
          if (m == 2) begin
            ee = 4'b1110; eo = lv & 4'b1110;
          end else if (m == 3) begin
            ee = 4'b1110;
            eo[1] = c[0] ? spi_din : lv[1];
            eo[2] = c[0] ? spi_sclk : lv[2];
            eo[3] = ~c[0];
          end
          ed = (m == 3) && c[0] && pin_in[0];
          check($sformatf("R6 R8 R9 R10 sweep out m%0d cs%0d p%0d", m, c, pat), {4'd0, pin_out}, {4'd0, eo});
          check($sformatf("R3 R6 sweep oe m%0d cs%0d p%0d", m, c, pat), {4'd0, pin_oe}, {4'd0, ee});
          check($sformatf("R7 sweep dout m%0d cs%0d p%0d", m, c, pat), {7'd0, spi_dout}, {7'd0, ed});
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_rw();
    t_gpin();
    t_gpout();
    t_wake();
    t_serial_cs_low();
    t_pullup();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule